// File: doc/BRIEF.md
# Byte-Interleaved Sample FIFO

This block queues results from an analog converter for a host that reads one byte at a time. Each conversion result is a 12-bit unsigned value with a 4-bit channel tag. On arrival the result is split into two bytes, and both bytes are written into a byte-wide store in the same cycle. The low byte goes in first and carries the four least significant data bits together with the tag. The high byte goes in second and carries the upper eight data bits. The host pops bytes through either of two read strobes. Both strobes drain the same queue, so a driver may read the low and high halves from two separate addresses.

The block keeps an empty flag, a half-full flag and a sticky overflow flag. A host clear strobe empties the queue. An interrupt request flip-flop is set either on every finished conversion or when the occupancy crosses up to half of capacity, depending on a mode input. It stays set until the host clears it. A read from an empty queue does not move any pointer and hands back the last byte again.

Top module: `sample_byte_fifo`

## Requirements
- R1: A pushed sample `push_data`/`push_chan` becomes two bytes. The first byte is `{push_data[3:0], push_chan[3:0]}` (data in bits 7..4, tag in bits 3..0). The second byte is `push_data[11:4]`.
- R2: A pulse on `rd_lo` or on `rd_hi` pops the next byte from the one shared queue. Pulsing both in the same cycle pops a single byte.
- R3: A read strobe while `empty` is 1 leaves `rd_data` at the last byte output and moves no pointer. The next sample pushed is the next one read.
- R4: A `fifo_clear` pulse gives `empty`=1, `half_full`=0 and `overflow`=0 after the next edge. It takes priority over a push or a pop in the same cycle.
- R5: `half_full` is 1 exactly when the occupancy is at least DEPTH/2 bytes.
- R6: A push that arrives while fewer than two bytes are free is discarded whole and sets `overflow`. `overflow` stays 1 until `fifo_clear`.
- R7: With `fifo_mode`=1, the request is raised when the occupancy moves from below DEPTH/2 to DEPTH/2 or more. Single conversions do not raise it in this mode.
- R8: With `fifo_mode`=0, every `push_valid` pulse (each finished conversion) raises the request.
- R9: `irq` stays 1 until an `irq_clear` pulse. A clear wins over an event in the same cycle. Events that arrive while `irq` is already 1 are absorbed.
- R10: After reset, `empty`=1, `half_full`=0, `overflow`=0, `irq`=0 and `rd_data`=0.
- R11: Bytes come out in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | One-cycle pulse: a conversion finished |
| push_data | input | 12 | Unsigned conversion result |
| push_chan | input | 4 | Channel tag of the result |
| rd_lo | input | 1 | Read strobe, first host address |
| rd_hi | input | 1 | Read strobe, second host address |
| rd_data | output | 8 | Last byte popped |
| fifo_clear | input | 1 | Host strobe that empties the queue |
| fifo_mode | input | 1 | 1: request at half full; 0: request per sample |
| irq_clear | input | 1 | Host strobe that drops the request |
| empty | output | 1 | Queue holds no bytes |
| half_full | output | 1 | Occupancy at least DEPTH/2 bytes |
| overflow | output | 1 | Sticky: a sample was discarded |
| irq | output | 1 | Interrupt request flip-flop |

## Verification
Every result is one register stage behind its stimulus:
- The flags, the occupancy and `irq` reflect a push, pop or clear after the rising edge that samples it.
- `rd_data` shows a popped byte after the edge that sees the read strobe.

The bench changes inputs one nanosecond after a rising edge and holds them across the next edge. It checks outputs one nanosecond after that edge, which is exactly when each result is due. A byte queue in the bench follows the pushes, pops and discards, and gives the expected value of every read.

// File: rtl/sbf_pkg.sv
// Package: shared byte type and the sample-to-byte packing rules.
// Assumes 12-bit samples with 4-bit tags.
package sbf_pkg;
    typedef logic [7:0] byte_t;

    // First byte of a sample: low data nibble above the channel tag
    function automatic byte_t first_byte(input logic [11:0] d, input logic [3:0] c);
        return {d[3:0], c};
    endfunction

    // Second byte of a sample: upper eight data bits
    function automatic byte_t second_byte(input logic [11:0] d);
        return d[11:4];
    endfunction
endpackage

// File: rtl/sbf_store.sv
// Byte store: writes the two bytes of a sample side by side in one cycle,
// and registers one byte per pop. With no pop, rd_data keeps its value.
// Assumes DEPTH is a power of two and the address width matches it.
module sbf_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  sbf_pkg::byte_t      wr_first,
    input  sbf_pkg::byte_t      wr_second,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output sbf_pkg::byte_t      rd_data
);
    sbf_pkg::byte_t mem [DEPTH];
    logic [AW-1:0]  wr_addr_nx;

    assign wr_addr_nx = wr_addr + AW'(1);

    // Write both bytes of an accepted sample in one cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr]    <= wr_first;
            mem[wr_addr_nx] <= wr_second;
        end
    end

    // Output register: load on pop, otherwise repeat the last byte
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/sbf_ctrl.sv
// Pointer and flag control. A push is accepted only when two bytes are free.
// A pop is accepted only when the queue is not empty. Clear overrides both.
// It also reports the upward crossing of the half-full level.
module sbf_ctrl #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clear,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic          rd_en,
    output logic [AW-1:0] rd_ptr,
    output logic          empty,
    output logic          half_full,
    output logic          overflow,
    output logic          half_rise
);
    localparam int          CW     = AW + 1;
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    logic [CW-1:0] count, count_nx, free;

    assign free      = CAP - count;
    assign wr_en     = push && !clear && (free >= CW'(2));
    assign rd_en     = pop && !clear && (count != '0);
    assign count_nx  = count + (wr_en ? CW'(2) : CW'(0)) - (rd_en ? CW'(1) : CW'(0));
    assign half_rise = !clear && (count < HALF) && (count_nx >= HALF);
    assign empty     = (count == '0);
    assign half_full = (count >= HALF);

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + AW'(2);
            if (rd_en) rd_ptr <= rd_ptr + AW'(1);
            count <= count_nx;
        end
    end

    // Sticky overflow: a discarded push sets it, only clear drops it
    always_ff @(posedge clk) begin
        if (!rst_n || clear)          overflow <= 1'b0;
        else if (push && !wr_en)      overflow <= 1'b1;
    end

    p_clear_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (empty && !half_full && !overflow));
    p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);
    p_empty_no_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clear) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/sbf_irq.sv
// Interrupt request flip-flop. The mode picks the event: half-full crossing
// or each conversion. A set flip-flop absorbs events, and a clear wins.
module sbf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic sample_evt,
    input  logic half_evt,
    input  logic irq_clear,
    output logic irq
);
    logic evt;

    assign evt = fifo_mode ? half_evt : sample_evt;

    // Request register: clear first, then set on an event
    always_ff @(posedge clk) begin
        if (!rst_n || irq_clear) irq <= 1'b0;
        else if (evt)            irq <= 1'b1;
    end

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |=> !irq);
endmodule

// File: rtl/sample_byte_fifo.sv
// Top: packs tagged 12-bit samples into byte pairs and queues them.
// Two read strobes pop one queue, and it drives the flags and the request.
// Assumes DEPTH is a power of two, at least 4.
module sample_byte_fifo #(
    parameter int DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic [11:0] push_data,
    input  logic [3:0]  push_chan,
    input  logic        rd_lo,
    input  logic        rd_hi,
    output logic [7:0]  rd_data,
    input  logic        fifo_clear,
    input  logic        fifo_mode,
    input  logic        irq_clear,
    output logic        empty,
    output logic        half_full,
    output logic        overflow,
    output logic        irq
);
    localparam int AW = $clog2(DEPTH);

    logic           pop, wr_en, rd_en, half_rise;
    logic [AW-1:0]  wr_ptr, rd_ptr;
    sbf_pkg::byte_t b_first, b_second;

    assign pop      = rd_lo | rd_hi;
    assign b_first  = sbf_pkg::first_byte(push_data, push_chan);
    assign b_second = sbf_pkg::second_byte(push_data);

    sbf_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push_valid), .pop(pop), .clear(fifo_clear),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_en(rd_en), .rd_ptr(rd_ptr),
        .empty(empty), .half_full(half_full), .overflow(overflow), .half_rise(half_rise)
    );

    sbf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_ptr),
        .wr_first(b_first), .wr_second(b_second),
        .rd_en(rd_en), .rd_addr(rd_ptr), .rd_data(rd_data)
    );

    sbf_irq u_irq (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .sample_evt(push_valid),
        .half_evt(half_rise), .irq_clear(irq_clear), .irq(irq)
    );

    p_empty_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !fifo_clear) |=> $stable(rd_data));
    p_half_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        half_full |-> !empty);
endmodule

// File: tb/sample_byte_fifo_bench.sv
`timescale 1ns/1ps
module sample_byte_fifo_bench;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
    logic fifo_clear = 1'b0, fifo_mode = 1'b0, irq_clear = 1'b0;
    logic [11:0] push_data = '0;
    logic [3:0]  push_chan = '0;
    logic [7:0]  rd_data;
    logic empty, half_full, overflow, irq;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] model[$];
    logic [7:0] last_b = 8'h00;

    always #2 clk = ~clk;

    sample_byte_fifo #(.DEPTH(DEPTH)) u_sample_byte_fifo (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_chan(push_chan), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data),
        .fifo_clear(fifo_clear), .fifo_mode(fifo_mode), .irq_clear(irq_clear),
        .empty(empty), .half_full(half_full), .overflow(overflow), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [11:0] d, input logic [3:0] c);
        push_valid = 1'b1; push_data = d; push_chan = c;
        cyc();
        push_valid = 1'b0;
        if (model.size() <= DEPTH - 2) begin
            model.push_back({d[3:0], c});
            model.push_back(d[11:4]);
        end
    endtask

    task automatic pop(input bit lo, input bit hi, input string req);
        rd_lo = lo; rd_hi = hi;
        cyc();
        rd_lo = 1'b0; rd_hi = 1'b0;
        if (model.size() > 0) last_b = model.pop_front();
        chk(req, "rd_data", rd_data, last_b);
    endtask

    task automatic do_clear();
        fifo_clear = 1'b1; cyc(); fifo_clear = 1'b0;
        model.delete();
    endtask

    task automatic drop_irq();
        irq_clear = 1'b1; cyc(); irq_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "empty", empty, 1);
        chk("R10", "half_full", half_full, 0);
        chk("R10", "overflow", overflow, 0);
        chk("R10", "irq", irq, 0);
        chk("R10", "rd_data", rd_data, 0);
    endtask

    task automatic t_pack_order();
        fifo_mode = 1'b0;
        push(12'hABC, 4'h5);
        push(12'h123, 4'hF);
        chk("R1", "first byte", model[0], 8'hC5);
        pop(1, 0, "R1");
        pop(1, 0, "R1");
        chk("R1", "high byte", rd_data, 8'hAB);
        pop(1, 0, "R11");
        pop(1, 0, "R11");
        chk("R11", "empty after drain", empty, 1);
        drop_irq();
    endtask

    task automatic t_both_ports();
        push(12'h4D2, 4'h1);
        push(12'h0F0, 4'h7);
        pop(0, 1, "R2");
        pop(1, 0, "R2");
        pop(1, 1, "R2");
        pop(0, 1, "R2");
        chk("R2", "empty after four pops", empty, 1);
        drop_irq();
    endtask

    task automatic t_empty_read();
        pop(1, 0, "R3");
        pop(0, 1, "R3");
        pop(1, 1, "R3");
        chk("R3", "still empty", empty, 1);
        push(12'h987, 4'h2);
        pop(1, 0, "R3");
        chk("R3", "new first byte", rd_data, 8'h72);
        do_clear();
        drop_irq();
    endtask

    task automatic t_half_fifo_mode();
        fifo_mode = 1'b1;
        for (int i = 0; i < 7; i++) push(12'(i * 37), 4'(i));
        chk("R5", "half_full below half", half_full, 0);
        chk("R7", "no per-sample irq in fifo mode", irq, 0);
        push(12'hFFF, 4'hE);
        chk("R5", "half_full at half", half_full, 1);
        chk("R7", "irq at half crossing", irq, 1);
        pop(1, 0, "R11");
        chk("R5", "half_full at half minus one", half_full, 0);
        push(12'h555, 4'h3);
        chk("R9", "irq held", irq, 1);
        drop_irq();
        chk("R9", "irq dropped", irq, 0);
        pop(1, 0, "R11");
        pop(1, 0, "R11");
        push(12'h111, 4'h1);
        chk("R7", "irq on second crossing", irq, 1);
        do_clear();
        drop_irq();
        fifo_mode = 1'b0;
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH / 2; i++) push(12'(i * 101), 4'(i));
        chk("R6", "no overflow when exactly full", overflow, 0);
        push(12'hDEA, 4'hD);
        chk("R6", "overflow set", overflow, 1);
        for (int i = 0; i < DEPTH; i++) pop(1, 0, "R6");
        chk("R6", "overflow sticky", overflow, 1);
        chk("R6", "empty after drain", empty, 1);
        do_clear();
        chk("R4", "overflow cleared", overflow, 0);
        chk("R4", "empty after clear", empty, 1);
        drop_irq();
    endtask

    task automatic t_clear_priority();
        push(12'h321, 4'h4);
        fifo_clear = 1'b1; push_valid = 1'b1; push_data = 12'h777; push_chan = 4'h7;
        cyc();
        fifo_clear = 1'b0; push_valid = 1'b0;
        model.delete();
        chk("R4", "clear beats push", empty, 1);
        chk("R4", "half_full after clear", half_full, 0);
        drop_irq();
    endtask

    task automatic t_irq_per_sample();
        fifo_mode = 1'b0;
        push(12'h010, 4'h0);
        chk("R8", "irq after one conversion", irq, 1);
        irq_clear = 1'b1;
        push(12'h020, 4'h0);
        irq_clear = 1'b0;
        chk("R9", "clear wins over event", irq, 0);
        push(12'h030, 4'h0);
        chk("R8", "irq after next conversion", irq, 1);
        do_clear();
        drop_irq();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        t_reset();
        t_pack_order();
        t_both_ports();
        t_empty_read();
        t_half_fifo_mode();
        t_overflow();
        t_clear_priority();
        t_irq_per_sample();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule